// File: doc/BRIEF.md
# Pipelined Cell-Array Unsigned Multiplier

This block multiplies two unsigned N-bit operands with a regular array of identical cells. Each cell ANDs one bit of each operand and adds the result into the running sum with a full adder. N rows of cells build the product in carry-save form, one row per cell level. A closing row of N-1 cells then resolves the remaining carries by ripple. The longest path through the array is therefore 2N-1 cell levels deep.

A register rank is placed after every STAGE_CELLS cell levels and after the last level. An input rank sits in front of the array. Each rank carries the operand bits that later levels still need, the partial sum and carry words, and a valid bit. Each product therefore leaves the block aligned with the operand pair that produced it.

The data interface is a plain valid stream with no ready signal. The block accepts a pair on every clock and cannot apply back-pressure, so the consumer must take every word that `out_valid` marks. While `out_valid` is low the product output has no meaning.

Top module: `guild_mul_pipe`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the unsigned product `in_a * in_b` of the pair accepted LAT cycles earlier, as a 2N-bit value.
- R2: LAT equals ceil((2N-1)/STAGE_CELLS) + 1 clock cycles. For N=7 and STAGE_CELLS=1 this is 14: a pair sampled at clock edge E appears after edge E+13.
- R3: A new pair is accepted on every clock with no stall. Back-to-back pairs give back-to-back products, in input order, each matching its own pair.
- R4: `out_valid` is `in_valid` delayed by exactly LAT cycles. A cycle with `in_valid` low gives a cycle with `out_valid` low LAT cycles later, and the pairs around it are unaffected.
- R5: `rst` is synchronous and active high. It clears every valid stage, so `out_valid` is low during reset and in each cycle after it until a pair accepted after reset completes its LAT cycles. Pairs in flight at reset never appear.
- R6: With STAGE_CELLS=2 and N=7, two cell levels share each rank and LAT is 8. R1, R3 and R4 still hold.
- R7: Corner operands give exact results for N=7: zero times anything is 0; 127*127 is 16129; 85*42 is 3570.
- R8: The operand width N is a parameter. With N=4 and STAGE_CELLS=1, LAT is 8 and all 256 operand pairs give correct 8-bit products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register is updated on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | Marks `in_a`/`in_b` as a pair to multiply this cycle |
| in_a | input | N | Unsigned multiplicand |
| in_b | input | N | Unsigned multiplier |
| out_valid | output | 1 | Marks `out_prod` as a finished product |
| out_prod | output | 2N | Unsigned product of the pair accepted LAT cycles earlier |

## Verification
On every cycle, a checker compares `out_valid` against a LAT-deep delay of `in_valid`. It compares each marked product against a delayed reference multiply, keeps products within the range that N-bit operands allow, and confirms that valid is low right after reset ends. Some behaviours only the bench scenarios can show. These are the exact latency figures for each STAGE_CELLS choice, the full sweep of the 4-bit configuration, the handling of bubbles and of a reset in the middle of a dense stream, and the arithmetic corner operands.

// File: rtl/gmul_pkg.sv
package gmul_pkg;

  // Number of cell levels from operand rank to product: N rows plus N-1 ripple cells.
  function automatic int gm_levels(input int n);
    return 2 * n - 1;
  endfunction

  // Total clock cycles from input sample to product.
  function automatic int gm_latency(input int n, input int stage_cells);
    return (gm_levels(n) + stage_cells - 1) / stage_cells + 1;
  endfunction

  // True when a register rank follows cell level lvl.
  function automatic bit gm_rank_after(input int lvl, input int n, input int stage_cells);
    return ((lvl % stage_cells) == 0) || (lvl == gm_levels(n));
  endfunction

endpackage

// File: rtl/gmul_level.sv
// One cell level of the array. Levels 1..N are carry-save rows of N cells each.
// Levels N+1..2N-1 are the closing ripple cells, one bit position per level.
module gmul_level #(
  parameter int N   = 7,
  parameter int LVL = 1
) (
  input  logic [N-1:0]   x_a,
  input  logic [N-1:0]   x_b,
  input  logic [2*N-1:0] x_s,
  input  logic [2*N-1:0] x_c,
  input  logic           x_rc,
  output logic [N-1:0]   y_a,
  output logic [N-1:0]   y_b,
  output logic [2*N-1:0] y_s,
  output logic [2*N-1:0] y_c,
  output logic           y_rc
);

  assign y_a = x_a;
  assign y_b = x_b;

  generate
    if (LVL <= N) begin : g_row
      localparam int ROW = LVL - 1;
      always_comb begin
        logic [1:0] t;
        y_s  = x_s;
        y_c  = '0;
        y_rc = x_rc;
        for (int j = 0; j < N; j++) begin
          t = 2'(x_a[j] & x_b[ROW]) + 2'(x_s[ROW + j]) + 2'(x_c[ROW + j]);
          y_s[ROW + j]     = t[0];
          y_c[ROW + j + 1] = t[1];
        end
      end
    end else begin : g_ripple
      localparam int K   = LVL - N;
      localparam int POS = N - 1 + K;
      always_comb begin
        logic [1:0] t;
        y_s  = x_s;
        y_c  = x_c;
        t    = 2'(x_s[POS]) + 2'(x_c[POS]) + 2'(x_rc);
        y_s[POS] = t[0];
        y_c[POS] = 1'b0;
        y_rc     = t[1];
        if (K == N - 1) begin
          y_s[2*N-1] = x_c[2*N-1] ^ t[1];
          y_c[2*N-1] = 1'b0;
          y_rc       = 1'b0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gmul_rank.sv
// One register rank: data without reset, valid cleared by synchronous reset.
module gmul_rank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q_valid <= 1'b0;
    else     q_valid <= d_valid;
  end

  always_ff @(posedge clk) begin
    q <= d;
  end

endmodule

// File: rtl/guild_mul_pipe.sv
module guild_mul_pipe
  import gmul_pkg::*;
#(
  parameter int N           = 7,
  parameter int STAGE_CELLS = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   in_a,
  input  logic [N-1:0]   in_b,
  output logic           out_valid,
  output logic [2*N-1:0] out_prod
);

  localparam int LEVELS = gm_levels(N);
  localparam int SW     = 6 * N + 1;

  logic [N-1:0]   a_w  [0:LEVELS];
  logic [N-1:0]   b_w  [0:LEVELS];
  logic [2*N-1:0] s_w  [0:LEVELS];
  logic [2*N-1:0] c_w  [0:LEVELS];
  logic           rc_w [0:LEVELS];
  logic           v_w  [0:LEVELS];

  logic [2*N-1:0] in_q;

  gmul_rank #(.W(2 * N)) u_in_rank (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d       ({in_a, in_b}),
    .q_valid (v_w[0]),
    .q       (in_q)
  );

  assign a_w[0]  = in_q[2*N-1:N];
  assign b_w[0]  = in_q[N-1:0];
  assign s_w[0]  = '0;
  assign c_w[0]  = '0;
  assign rc_w[0] = 1'b0;

  generate
    for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
      logic [N-1:0]   la, lb;
      logic [2*N-1:0] ls, lc;
      logic           lrc;

      gmul_level #(.N(N), .LVL(k)) u_level (
        .x_a  (a_w[k-1]),
        .x_b  (b_w[k-1]),
        .x_s  (s_w[k-1]),
        .x_c  (c_w[k-1]),
        .x_rc (rc_w[k-1]),
        .y_a  (la),
        .y_b  (lb),
        .y_s  (ls),
        .y_c  (lc),
        .y_rc (lrc)
      );

      if (gm_rank_after(k, N, STAGE_CELLS)) begin : g_reg
        logic [SW-1:0] pq;
        gmul_rank #(.W(SW)) u_rank (
          .clk     (clk),
          .rst     (rst),
          .d_valid (v_w[k-1]),
          .d       ({la, lb, ls, lc, lrc}),
          .q_valid (v_w[k]),
          .q       (pq)
        );
        assign {a_w[k], b_w[k], s_w[k], c_w[k], rc_w[k]} = pq;
      end else begin : g_wire
        assign a_w[k]  = la;
        assign b_w[k]  = lb;
        assign s_w[k]  = ls;
        assign c_w[k]  = lc;
        assign rc_w[k] = lrc;
        assign v_w[k]  = v_w[k-1];
      end
    end
  endgenerate

  assign out_valid = v_w[LEVELS];
  assign out_prod  = s_w[LEVELS];

endmodule

// File: rtl/guild_mul_pipe_chk.sv
module guild_mul_pipe_chk
  import gmul_pkg::*;
#(
  parameter int N           = 7,
  parameter int STAGE_CELLS = 1
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N-1:0]   in_a,
  input logic [N-1:0]   in_b,
  input logic           out_valid,
  input logic [2*N-1:0] out_prod
);

  localparam int LAT = gm_latency(N, STAGE_CELLS);
  localparam logic [2*N-1:0] MAXP = (2*N)'(((2**N) - 1) * ((2**N) - 1));

  logic [LAT-1:0] v_sh;
  logic [2*N-1:0] p_sh [LAT];

  always_ff @(posedge clk) begin
    if (rst) v_sh <= '0;
    else     v_sh <= {v_sh[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    p_sh[0] <= (2*N)'(in_a) * (2*N)'(in_b);
    for (int k = 1; k < LAT; k++) p_sh[k] <= p_sh[k-1];
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sh[LAT-1]); // R2
  AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (rst)
    !v_sh[LAT-1] |-> !out_valid); // R4
  AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_prod == p_sh[LAT-1]); // R1
  AST_PRODUCT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_prod <= MAXP); // R1
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid); // R5

endmodule

bind guild_mul_pipe guild_mul_pipe_chk #(.N(N), .STAGE_CELLS(STAGE_CELLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_prod  (out_prod)
);

// File: tb/guild_mul_pipe_bench.sv
module guild_mul_pipe_bench;

  localparam int NIT    = 720;
  localparam int LAT1   = 14; // N=7, one cell level per rank (R2)
  localparam int LAT2   = 8;  // N=7, two cell levels per rank (R6)
  localparam int LAT4   = 8;  // N=4, one cell level per rank (R8)
  localparam int RST_AT = 450;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       vin = 1'b0;
  logic [6:0] a7 = '0, b7 = '0;
  logic [3:0] a4 = '0, b4 = '0;
  logic        ov1, ov2, ov4;
  logic [13:0] op1, op2;
  logic [7:0]  op4;

  guild_mul_pipe #(.N(7), .STAGE_CELLS(1)) u_guild_mul_pipe (
    .clk(clk), .rst(rst), .in_valid(vin), .in_a(a7), .in_b(b7),
    .out_valid(ov1), .out_prod(op1));

  guild_mul_pipe #(.N(7), .STAGE_CELLS(2)) u_guild_mul_pipe_s2 (
    .clk(clk), .rst(rst), .in_valid(vin), .in_a(a7), .in_b(b7),
    .out_valid(ov2), .out_prod(op2));

  guild_mul_pipe #(.N(4), .STAGE_CELLS(1)) u_guild_mul_pipe_n4 (
    .clk(clk), .rst(rst), .in_valid(vin), .in_a(a4), .in_b(b4),
    .out_valid(ov4), .out_prod(op4));

  int n_chk = 0;
  int n_fail = 0;
  bit hv  [NIT];
  int ha7 [NIT];
  int hb7 [NIT];
  int ha4 [NIT];
  int hb4 [NIT];
  logic [31:0] rs = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Tag for a valid-flag check on an output that belongs to input index idx.
  function automatic string vtag(input int idx, input string base);
    if (idx > RST_AT - LAT1 && idx <= RST_AT + 2) return "R5";
    if (idx >= 300 && idx < 360) return "R4";
    return base;
  endfunction

  task automatic check_dut(input int u, input int lat, input string base,
                           input logic ov, input longint op, input bit wide);
    int idx;
    bit ev;
    longint ep;
    string tg;
    idx = u - lat;
    ev  = (idx >= 0) ? hv[idx] : 1'b0;
    chk(ov == ev, vtag(idx, base), "out_valid", longint'(ov), longint'(ev));
    if (ev) begin
      ep = wide ? longint'(ha7[idx]) * hb7[idx] : longint'(ha4[idx]) * hb4[idx];
      tg = base;
      if (base == "R2") begin
        if (idx < 16) tg = "R7";
        else if (idx > 0 && hv[idx-1]) tg = "R3";
        else tg = "R1";
      end
      chk(op == ep, tg, "out_prod", op, ep);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5: nothing marked valid while reset is held
    chk(ov1 == 1'b0, "R5", "out_valid s1 in reset", longint'(ov1), 0);
    chk(ov2 == 1'b0, "R5", "out_valid s2 in reset", longint'(ov2), 0);
    chk(ov4 == 1'b0, "R5", "out_valid n4 in reset", longint'(ov4), 0);

    for (int u = 0; u < NIT; u++) begin
      if (u > 0) @(negedge clk);
      check_dut(u, LAT1, "R2", ov1, longint'(op1), 1'b1);
      check_dut(u, LAT2, "R6", ov2, longint'(op2), 1'b1);
      check_dut(u, LAT4, "R8", ov4, longint'(op4), 1'b0);

      rst = (u == RST_AT);
      if (u >= NIT - 30)              vin = 1'b0;
      else if (u >= 300 && u < 360)   vin = (u % 3) != 0;
      else                            vin = 1'b1;

      rs = nxt(rs);
      case (u)
        0:  begin a7 = 7'd0;   b7 = 7'd0;   end
        1:  begin a7 = 7'd127; b7 = 7'd127; end
        2:  begin a7 = 7'd85;  b7 = 7'd42;  end
        3:  begin a7 = 7'd42;  b7 = 7'd85;  end
        4:  begin a7 = 7'd127; b7 = 7'd0;   end
        5:  begin a7 = 7'd0;   b7 = 7'd127; end
        6:  begin a7 = 7'd1;   b7 = 7'd127; end
        7:  begin a7 = 7'd127; b7 = 7'd1;   end
        8:  begin a7 = 7'd64;  b7 = 7'd64;  end
        9:  begin a7 = 7'd127; b7 = 7'd126; end
        10: begin a7 = 7'd85;  b7 = 7'd85;  end
        11: begin a7 = 7'd42;  b7 = 7'd42;  end
        12: begin a7 = 7'd1;   b7 = 7'd1;   end
        13: begin a7 = 7'd120; b7 = 7'd15;  end
        14: begin a7 = 7'd99;  b7 = 7'd127; end
        15: begin a7 = 7'd127; b7 = 7'd85;  end
        default: begin a7 = rs[6:0]; b7 = rs[13:7]; end
      endcase
      if (u < 256) begin
        a4 = 4'(u);
        b4 = 4'(u >> 4);
      end else begin
        a4 = rs[19:16];
        b4 = rs[23:20];
      end

      if (rst) for (int t = 0; t < u; t++) hv[t] = 1'b0;
      hv[u]  = vin && !rst;
      ha7[u] = int'(a7);
      hb7[u] = int'(b7);
      ha4[u] = int'(a4);
      hb4[u] = int'(b4);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule